// File: doc/BRIEF.md
# Byte-Lane Memory Responder

This block is the memory slave on a 32-bit big-endian processor bus. A master puts an address, an access width, a write flag, an instruction-fetch flag and (for writes) data on the bus, then raises a request strobe. The responder takes the request, waits a fixed number of cycles set by a parameter, and then raises `ready` for exactly one cycle. The master samples `ready` away from the active clock edge. It keeps the request up until it has seen `ready`, then lowers the strobe.

Reads always return the whole addressed word, and the master picks out the lanes it needs. Writes change only the byte lanes that the width and the low address bits select. Data on the bus is already placed in its lane, so it is never shifted. Storage is a word array, indexed by the address above the byte offset and cleared by reset. The fetch flag of the request being answered is shown on a status output while `ready` is high. In this design the two-phase clock is reduced to a single clock `clk`: the master drives on the falling edge and the responder acts on the rising edge.

Top module: `mem_responder`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ready`, `rdata` and `fetch_flag` are 0. Reset clears every storage word to zero.
- R2: The responder accepts a request on the first rising edge at which it is idle and sees `mem_en` high. `ready` rises on the (WAIT_STATES+1)-th rising edge counted from that edge, and never earlier.
- R3: `ready` is high for exactly one cycle per request.
- R4: After answering, the responder ignores `mem_en` until `mem_en` has been seen low. A request held past `ready` therefore produces no second `ready`.
- R5: A read (`wr_en`=0) returns the full word at index `addr[9:2]`, whatever the width and `addr[1:0]`. `rdata` is zero whenever `ready` is low and during a write response.
- R6: A word write (width code 2) stores all four lanes.
- R7: A halfword write (width code 1) stores bits 31:16 when `addr[1]`=0 and bits 15:0 when `addr[1]`=1. The other half is unchanged.
- R8: A byte write (width code 0) stores only the lane at offset `addr[1:0]`. Offset 0 is bits 31:24, 1 is 23:16, 2 is 15:8 and 3 is 7:0. The other lanes are unchanged, whatever the bus carries in them.
- R9: A write with the reserved width code 3 changes no storage.
- R10: While `ready` is high, `fetch_flag` equals the `fetch_in` value of the request being answered. Otherwise it is 0.
- R11: Reset asserted during a pending request aborts it. No `ready` is produced for it, and after reset its address reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the responder acts on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Request strobe from the master |
| wr_en | input | 1 | 1 = write request, 0 = read |
| fetch_in | input | 1 | Instruction-fetch flag of the request |
| acc_width | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr | input | 10 | Byte address; bits 9:2 select the word |
| wdata | input | 32 | Write data, already in its big-endian lanes |
| ready | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read word, valid while `ready` is high |
| fetch_flag | output | 1 | Fetch flag of the request being answered |

## Verification
The assertions assume the master follows the handshake. It keeps `mem_en` and the request fields steady from the moment it raises the strobe until it has seen `ready`, and only then lowers the strobe. They also assume that reset is the only way a request is abandoned. The stimulus drives every bus change on the falling edge. It holds each request until the slower of two responders, one built with three wait cycles and one with none, has answered. It then lowers the strobe for at least one idle cycle before the next request. The only aborted request is the one cut off by reset.

// File: rtl/memrsp_pkg.sv
package memrsp_pkg;

    localparam int BUS_W      = 32;
    localparam int LANE_W     = 8;
    localparam int LANES      = BUS_W / LANE_W;
    localparam int OFFSET_W   = $clog2(LANES);
    localparam int MEM_ADDR_W = 10;
    localparam int INDEX_W    = MEM_ADDR_W - OFFSET_W;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_NONE = 2'd3
    } acc_width_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RESP,
        ST_HOLD
    } hs_state_e;

    typedef struct packed {
        logic [MEM_ADDR_W-1:0] addr;
        logic [BUS_W-1:0]      data;
        acc_width_e            width;
        logic                  write;
        logic                  fetch;
    } bus_req_t;

    // Enable bit i covers bus bits 8i+7:8i; byte offset 0 is the top lane.
    function automatic logic [LANES-1:0] lane_enables(acc_width_e w,
                                                      logic [OFFSET_W-1:0] off);
        logic [LANES-1:0] en;
        en = '0;
        case (w)
            ACC_BYTE: en[LANES-1-off] = 1'b1;
            ACC_HALF: en = off[OFFSET_W-1] ? {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}}
                                           : {{(LANES/2){1'b1}}, {(LANES/2){1'b0}}};
            ACC_WORD: en = '1;
            default:  en = '0;
        endcase
        return en;
    endfunction

endpackage

// File: rtl/memrsp_handshake.sv
module memrsp_handshake
    import memrsp_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mem_en,
    output logic accept,
    output logic commit,
    output logic ready
);
    localparam int CNT_W = $clog2(WAIT_STATES + 2);

    hs_state_e        state;
    logic [CNT_W-1:0] cnt;

    assign accept = (state == ST_IDLE) && mem_en;

    generate
        if (WAIT_STATES == 0) begin : g_nowait
            assign commit = accept;
        end else begin : g_wait
            assign commit = (state == ST_WAIT) && (cnt == CNT_W'(1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            ready <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (mem_en) begin
                        if (WAIT_STATES == 0) begin
                            state <= ST_RESP;
                            ready <= 1'b1;
                        end else begin
                            state <= ST_WAIT;
                            cnt   <= CNT_W'(WAIT_STATES);
                        end
                    end
                end
                ST_WAIT: begin
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_RESP;
                        ready <= 1'b1;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_RESP: begin
                    ready <= 1'b0;
                    state <= mem_en ? ST_HOLD : ST_IDLE;
                end
                default: begin
                    if (!mem_en) state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/memrsp_lane_decode.sv
module memrsp_lane_decode
    import memrsp_pkg::*;
(
    input  bus_req_t            req,
    input  logic                commit,
    output logic [LANES-1:0]    lane_we,
    output logic [INDEX_W-1:0]  index
);
    logic [LANES-1:0] en;

    always_comb begin
        en      = lane_enables(req.width, req.addr[OFFSET_W-1:0]);
        lane_we = (commit && req.write) ? en : '0;
        index   = req.addr[MEM_ADDR_W-1:OFFSET_W];
    end

endmodule

// File: rtl/memrsp_store.sv
module memrsp_store
    import memrsp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [LANES-1:0]    lane_we,
    input  logic [INDEX_W-1:0]  index,
    input  logic [BUS_W-1:0]    wdata,
    output logic [BUS_W-1:0]    rd_word
);
    localparam int DEPTH = 1 << INDEX_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < DEPTH; w++) lane_mem[w] <= '0;
            end else if (lane_we[g]) begin
                lane_mem[index] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = lane_mem[index];
    end

endmodule

// File: rtl/mem_responder.sv
module mem_responder
    import memrsp_pkg::*;
#(
    parameter int WAIT_STATES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mem_en,
    input  logic                  wr_en,
    input  logic                  fetch_in,
    input  logic [1:0]            acc_width,
    input  logic [MEM_ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]      wdata,
    output logic                  ready,
    output logic [BUS_W-1:0]      rdata,
    output logic                  fetch_flag
);
    logic             accept;
    logic             commit;
    bus_req_t         live_req;
    bus_req_t         held_req;
    bus_req_t         eff_req;
    logic [LANES-1:0] lane_we;
    logic [INDEX_W-1:0] index;
    logic [BUS_W-1:0] rd_word;

    memrsp_handshake #(.WAIT_STATES(WAIT_STATES)) u_hs (
        .clk    (clk),
        .rst    (rst),
        .mem_en (mem_en),
        .accept (accept),
        .commit (commit),
        .ready  (ready)
    );

    always_comb begin
        live_req.addr  = addr;
        live_req.data  = wdata;
        live_req.width = acc_width_e'(acc_width);
        live_req.write = wr_en;
        live_req.fetch = fetch_in;
        eff_req        = accept ? live_req : held_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_req <= '0;
        end else if (accept) begin
            held_req <= live_req;
        end
    end

    memrsp_lane_decode u_dec (
        .req     (eff_req),
        .commit  (commit),
        .lane_we (lane_we),
        .index   (index)
    );

    memrsp_store u_mem (
        .clk     (clk),
        .rst     (rst),
        .lane_we (lane_we),
        .index   (index),
        .wdata   (eff_req.data),
        .rd_word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata      <= '0;
            fetch_flag <= 1'b0;
        end else if (commit) begin
            rdata      <= eff_req.write ? '0 : rd_word;
            fetch_flag <= eff_req.fetch;
        end else begin
            rdata      <= '0;
            fetch_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/memrsp_chk.sv
module memrsp_chk
    import memrsp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             mem_en,
    input logic             ready,
    input logic [BUS_W-1:0] rdata,
    input logic             fetch_flag
);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    a_r2_needs_request: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(mem_en));

    a_r10_flag_quiet: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !fetch_flag);

    a_r5_data_quiet: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (rdata == '0));

    a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ready && !fetch_flag && rdata == '0));

    a_r4_no_repeat: assert property (@(posedge clk) disable iff (rst)
        (ready && mem_en) |=> (!ready && $stable(mem_en)) or !mem_en);

endmodule

bind mem_responder memrsp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_en     (mem_en),
    .ready      (ready),
    .rdata      (rdata),
    .fetch_flag (fetch_flag)
);

// File: tb/sim_mem_responder.sv
`timescale 1ns/1ps
module sim_mem_responder;
    localparam int W0 = 3;
    localparam int W1 = 0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        fetch_in = 1'b0;
    logic [1:0]  acc_width = 2'd2;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;

    logic        ready0, ready1, ff0, ff1;
    logic [31:0] rdata0, rdata1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [31:0] ref_mem [0:255];
    logic [31:0] got0, got1;
    logic        gf0, gf1;

    always #2.5 clk = ~clk;

    mem_responder #(.WAIT_STATES(W0)) u0 (
        .clk(clk), .rst(rst), .mem_en(mem_en), .wr_en(wr_en), .fetch_in(fetch_in),
        .acc_width(acc_width), .addr(addr), .wdata(wdata),
        .ready(ready0), .rdata(rdata0), .fetch_flag(ff0)
    );

    mem_responder #(.WAIT_STATES(W1)) u1 (
        .clk(clk), .rst(rst), .mem_en(mem_en), .wr_en(wr_en), .fetch_in(fetch_in),
        .acc_width(acc_width), .addr(addr), .wdata(wdata),
        .ready(ready1), .rdata(rdata1), .fetch_flag(ff1)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ref_clear();
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
    endtask

    task automatic ref_write(input logic [1:0] w, input logic [9:0] a, input logic [31:0] d);
        int o;
        o = int'(a[1:0]);
        case (w)
            2'd0: ref_mem[a[9:2]][31-8*o -: 8] = d[31-8*o -: 8];
            2'd1: begin
                if (a[1]) ref_mem[a[9:2]][15:0] = d[15:0];
                else      ref_mem[a[9:2]][31:16] = d[31:16];
            end
            2'd2: ref_mem[a[9:2]] = d;
            default: ;
        endcase
    endtask

    // One complete handshake; every cycle the ready of both responders is
    // compared with the cycle in which it is due (R2, R3, R4).
    task automatic bus_op(input logic wr, input logic fe, input logic [1:0] w,
                          input logic [9:0] a, input logic [31:0] d, input string tag);
        int k;
        logic [31:0] exp;
        @(negedge clk);
        wr_en = wr; fetch_in = fe; acc_width = w; addr = a; wdata = d; mem_en = 1'b1;
        k = 0;
        got0 = '0; got1 = '0; gf0 = 1'b0; gf1 = 1'b0;
        while (1) begin
            @(negedge clk);
            k++;
            chk(ready0 == (k == W0 + 1), {"R2 ready timing slow unit ", tag}, 32'(ready0), 32'(k == W0 + 1));
            chk(ready1 == (k == W1 + 1), {"R4 ready/hold fast unit ", tag}, 32'(ready1), 32'(k == W1 + 1));
            if (ready1) begin got1 = rdata1; gf1 = ff1; end
            if (ready0) begin got0 = rdata0; gf0 = ff0; break; end
            if (k > 20) break;
        end
        mem_en = 1'b0; wr_en = 1'b0; wdata = '0;
        @(negedge clk);
        chk(!ready0 && !ready1, {"R3 ready single pulse ", tag}, {30'd0, ready1, ready0}, 32'd0);
        exp = wr ? 32'd0 : ref_mem[a[9:2]];
        chk(got0 == exp, {"R5 rdata slow unit ", tag}, got0, exp);
        chk(got1 == exp, {"R5 rdata fast unit ", tag}, got1, exp);
        chk(gf0 == fe && gf1 == fe, {"R10 fetch flag ", tag}, {30'd0, gf1, gf0}, 32'(fe));
        if (wr) ref_write(w, a, d);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        ref_clear();
        repeat (3) @(negedge clk);
        chk(!ready0 && !ready1, "R1 ready low in reset", {30'd0, ready1, ready0}, 0);
        chk(rdata0 == 0 && !ff0, "R1 outputs low in reset", rdata0, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!ready0 && rdata0 == 0 && !ff0, "R1 outputs low after reset", rdata0, 0);

        bus_op(0, 0, 2'd2, 10'h010, 0, "R1 cleared word");
        bus_op(1, 0, 2'd2, 10'h020, 32'h11223344, "R6 word write");
        bus_op(0, 0, 2'd2, 10'h020, 0, "R6 word read");
        bus_op(0, 0, 2'd0, 10'h023, 0, "R5 byte-width read full word");
        bus_op(1, 0, 2'd1, 10'h022, 32'h5555AABB, "R7 low half write");
        bus_op(0, 0, 2'd2, 10'h020, 0, "R7 low half read");
        bus_op(1, 0, 2'd1, 10'h020, 32'hCCDD6666, "R7 high half write");
        bus_op(0, 0, 2'd1, 10'h021, 0, "R7 high half read");
        bus_op(1, 0, 2'd2, 10'h040, 32'hFFFFFFFF, "R6 fill word");
        for (int o = 0; o < 4; o++) begin
            bus_op(1, 0, 2'd0, 10'h040 + 10'(o), 32'h12345678 + 32'(o * 32'h01010101), "R8 byte write");
            bus_op(0, 0, 2'd2, 10'h040, 0, "R8 byte lane readback");
        end
        bus_op(1, 0, 2'd3, 10'h020, 32'hDEADBEEF, "R9 reserved width write");
        bus_op(0, 0, 2'd2, 10'h020, 0, "R9 word unchanged");
        bus_op(0, 1, 2'd2, 10'h020, 0, "R10 fetch read");
        bus_op(0, 0, 2'd2, 10'h040, 0, "R10 data read");

        // R11: reset cuts off a pending write before the slow unit answers.
        @(negedge clk);
        wr_en = 1'b1; acc_width = 2'd2; addr = 10'h060; wdata = 32'hA5A5A5A5; mem_en = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ready0 && !ready1, "R11 no ready during reset", {30'd0, ready1, ready0}, 0);
        mem_en = 1'b0; wr_en = 1'b0; wdata = '0;
        rst = 1'b0;
        ref_clear();
        repeat (W0 + 3) begin
            @(negedge clk);
            chk(!ready0 && !ready1, "R11 aborted request gives no ready", {30'd0, ready1, ready0}, 0);
        end
        bus_op(0, 0, 2'd2, 10'h060, 0, "R11 aborted write absent");
        bus_op(0, 0, 2'd2, 10'h020, 0, "R1 storage cleared by reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule